// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a register-programmed watchdog for a single processor domain. After software starts it, a down-counter runs through two back-to-back intervals. When the first interval runs out, the block raises an interrupt request. If software still has not restarted the count when the second interval runs out, the block sends a one-cycle escalation pulse to a watchdog in another domain. It never resets anything itself. The counter steps once per tick of an internal prescaler. The number of system clocks per tick is a parameter, so the default setting gives 1 MHz ticks from a 200 MHz clock.

Software uses a small register bus. The control word at offset 0x0 has three bits. Bit 0 is a write-1 trigger that restarts the count. Bit 1 is the unlock that protects both timeout registers. Bit 2 enables the interrupt request, and writing it as 0 drops a pending request. The first-stage timeout sits at 0x4 and the second-stage timeout at 0x8. The live count is read-only at 0xC. Bit 0 of 0x10 lets a pending request through to the interrupt pin. Both timeouts at zero means the watchdog is off.

The sequencer has four states: `ST_IDLE` (stopped or disabled), `ST_IRQ_WAIT` (first interval), `ST_ESC_WAIT` (second interval) and `ST_SPENT` (escalated, parked at zero). The transitions are:
- `ST_IDLE` to `ST_IRQ_WAIT` on a trigger.
- `ST_IRQ_WAIT` to `ST_ESC_WAIT` when the first interval runs out.
- `ST_ESC_WAIT` to `ST_SPENT` when the second interval runs out.
- Any state to `ST_IRQ_WAIT` on a trigger.
- Any state to `ST_IDLE` while both timeouts are zero.

Top module: `esc_wdog_top`

## Requirements
- R1: After synchronous reset, every register reads 0, `irq_o` and `esc_o` are low, and the count stays 0 with no trigger.
- R2: The control word reads back bit 1 (unlock) and bit 2 (interrupt enable), and bit 0 (trigger) always reads 0. The mask at 0x10 reads back bit 0. Any unmapped offset reads 0.
- R3: A write to 0x4 or 0x8 is ignored while the unlock bit (control bit 1) is 0, and takes effect while it is 1.
- R4: A trigger loads the count with the first-stage timeout N and restarts the prescaler. The count then drops by one every TICK_DIV clocks, and the live value is readable at 0xC.
- R5: N ticks (N*TICK_DIV clocks) after the trigger, the count loads the second-stage timeout M. If the interrupt enable is 1, the request becomes pending, and `irq_o` = pending AND mask bit 0.
- R6: With mask bit 0 clear, `irq_o` stays low through a first-stage expiry. The request stays pending and drives `irq_o` high as soon as the mask bit is set.
- R7: A pending request is dropped by a control write with bit 2 = 0, and also by a trigger.
- R8: M ticks after the first-stage expiry, `esc_o` pulses high for exactly one clock. The count then reads 0 and stays 0 until the next trigger.
- R9: While both timeouts are 0, the block counts nothing (count 0) and raises neither `irq_o` nor `esc_o`, even after a trigger. Zeroing both timeouts while running stops it.
- R10: A trigger that lands in the same clock as an expiry wins. No interrupt or escalation is raised, and the count reloads N.
- R11: A retrigger before the first-stage expiry restarts the full first interval, and no interrupt is raised in between.
- R12: A zero timeout for one stage while the other is nonzero lasts exactly one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from the address) |
| irq_o | output | 1 | Interrupt request after masking |
| esc_o | output | 1 | One-cycle escalation pulse to the peer watchdog |

## Verification
The hardest case to reach from the ports is a trigger write that lands on exactly the clock edge where a stage expires. The bench gets there by counting edges from its own trigger write. It uses a small TICK_DIV and a known timeout, and it relies on the prescaler restarting on every trigger. The expiry edge is therefore exactly N*TICK_DIV clocks after that trigger. The bench then issues the second write on that edge and checks that the count reloads with no interrupt. It also checks that the next expiry comes one full interval later.

// File: rtl/esc_wdog_pkg.sv
package esc_wdog_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_IRQ_TMO = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_ESC_TMO = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_COUNT   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_MASK    = 5'h10;

    localparam int CB_TRIG   = 0;
    localparam int CB_UNLOCK = 1;
    localparam int CB_IRQEN  = 2;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_IRQ_WAIT = 2'd1,
        ST_ESC_WAIT = 2'd2,
        ST_SPENT    = 2'd3
    } wd_state_t;

endpackage

// File: rtl/esc_wdog_tick.sv
module esc_wdog_tick #(
    parameter int TICK_DIV = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick_o
);

    generate
        if (TICK_DIV <= 1) begin : g_passthru
            assign tick_o = 1'b1;
        end else begin : g_divider
            localparam int PW = $clog2(TICK_DIV);
            localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

            logic [PW-1:0] phase;

            assign tick_o = (phase == LAST);

            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    phase <= '0;
                end else if (tick_o) begin
                    phase <= '0;
                end else begin
                    phase <= phase + PW'(1);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/esc_wdog_regs.sv
module esc_wdog_regs
    import esc_wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count_i,
    output logic              trig_o,
    output logic              pend_clr_o,
    output logic              unlock_o,
    output logic              irq_en_o,
    output logic              irq_pass_o,
    output logic [CNT_W-1:0]  irq_tmo_o,
    output logic [CNT_W-1:0]  esc_tmo_o
);

    logic wr_hit;
    logic ctrl_wr;
    logic unused_bits;

    assign wr_hit      = bus_sel && bus_wr;
    assign ctrl_wr     = wr_hit && (bus_addr == OFS_CTRL);
    assign trig_o      = ctrl_wr && bus_wdata[CB_TRIG];
    assign pend_clr_o  = ctrl_wr && !bus_wdata[CB_IRQEN];
    assign unused_bits = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            unlock_o   <= 1'b0;
            irq_en_o   <= 1'b0;
            irq_pass_o <= 1'b0;
            irq_tmo_o  <= '0;
            esc_tmo_o  <= '0;
        end else if (wr_hit) begin
            unique case (bus_addr)
                OFS_CTRL: begin
                    unlock_o <= bus_wdata[CB_UNLOCK];
                    irq_en_o <= bus_wdata[CB_IRQEN];
                end
                OFS_IRQ_TMO: if (unlock_o) irq_tmo_o <= bus_wdata[CNT_W-1:0];
                OFS_ESC_TMO: if (unlock_o) esc_tmo_o <= bus_wdata[CNT_W-1:0];
                OFS_MASK:    irq_pass_o <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[CB_UNLOCK] = unlock_o;
                bus_rdata[CB_IRQEN]  = irq_en_o;
            end
            OFS_IRQ_TMO: bus_rdata = DATA_W'(irq_tmo_o);
            OFS_ESC_TMO: bus_rdata = DATA_W'(esc_tmo_o);
            OFS_COUNT:   bus_rdata = DATA_W'(count_i);
            OFS_MASK:    bus_rdata[0] = irq_pass_o;
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/esc_wdog_fsm.sv
module esc_wdog_fsm
    import esc_wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             trig,
    input  logic             irq_en,
    input  logic             pend_clr,
    input  logic [CNT_W-1:0] irq_tmo,
    input  logic [CNT_W-1:0] esc_tmo,
    output logic [CNT_W-1:0] count_o,
    output logic             pend_o,
    output logic             esc_o,
    output wd_state_t        state_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wd_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             set_pend;
    logic             fire_esc;
    logic             disabled;

    assign disabled = (irq_tmo == '0) && (esc_tmo == '0);
    assign count_o  = cnt_q;
    assign state_o  = state_q;

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        set_pend = 1'b0;
        fire_esc = 1'b0;
        if (disabled) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (trig) begin
            state_d = ST_IRQ_WAIT;
            cnt_d   = irq_tmo;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_IRQ_WAIT: begin
                    if (tick) begin
                        if (cnt_q <= ONE) begin
                            state_d  = ST_ESC_WAIT;
                            cnt_d    = esc_tmo;
                            set_pend = irq_en;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                ST_ESC_WAIT: begin
                    if (tick) begin
                        if (cnt_q <= ONE) begin
                            state_d  = ST_SPENT;
                            cnt_d    = '0;
                            fire_esc = 1'b1;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                ST_SPENT: cnt_d = '0;
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            esc_o  <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            esc_o  <= fire_esc;
            pend_o <= (pend_o || set_pend) && !(pend_clr || trig);
        end
    end

endmodule

// File: rtl/esc_wdog_top.sv
module esc_wdog_top
    import esc_wdog_pkg::*;
#(
    parameter int TICK_DIV = 200,
    parameter int CNT_W    = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        esc_o
);

    logic             trig;
    logic             pend_clr;
    logic             ctrl_unlock;
    logic             irq_en;
    logic             irq_pass;
    logic [CNT_W-1:0] tmo_irq;
    logic [CNT_W-1:0] tmo_esc;
    logic [CNT_W-1:0] wd_count;
    logic             pend;
    logic             tick;
    wd_state_t        wd_state;

    esc_wdog_regs #(.CNT_W(CNT_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .count_i    (wd_count),
        .trig_o     (trig),
        .pend_clr_o (pend_clr),
        .unlock_o   (ctrl_unlock),
        .irq_en_o   (irq_en),
        .irq_pass_o (irq_pass),
        .irq_tmo_o  (tmo_irq),
        .esc_tmo_o  (tmo_esc)
    );

    esc_wdog_tick #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk     (clk),
        .rst     (rst),
        .restart (trig),
        .tick_o  (tick)
    );

    esc_wdog_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .trig     (trig),
        .irq_en   (irq_en),
        .pend_clr (pend_clr),
        .irq_tmo  (tmo_irq),
        .esc_tmo  (tmo_esc),
        .count_o  (wd_count),
        .pend_o   (pend),
        .esc_o    (esc_o),
        .state_o  (wd_state)
    );

    assign irq_o = pend && irq_pass;

endmodule

// File: rtl/esc_wdog_chk.sv
module esc_wdog_chk
    import esc_wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [4:0]       bus_addr,
    input logic             unlock,
    input logic [CNT_W-1:0] tmo_irq,
    input logic [CNT_W-1:0] tmo_esc,
    input logic             trig,
    input logic             pend_clr,
    input logic             pend,
    input logic [CNT_W-1:0] count,
    input logic             esc_o
);

    logic off_now;
    assign off_now = (tmo_irq == '0) && (tmo_esc == '0);

    // R3
    irq_tmo_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == OFS_IRQ_TMO && !unlock) |=> $stable(tmo_irq));

    // R3
    esc_tmo_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == OFS_ESC_TMO && !unlock) |=> $stable(tmo_esc));

    // R8
    esc_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        esc_o |=> !esc_o);

    // R8
    esc_count_zero_chk: assert property (@(posedge clk) disable iff (rst)
        esc_o |-> (count == '0));

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        off_now |=> (!esc_o && count == '0));

    // R10
    trig_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (trig && !off_now) |=> (!esc_o && !pend && count == $past(tmo_irq)));

    // R7
    pend_drop_chk: assert property (@(posedge clk) disable iff (rst)
        pend_clr |=> !pend);

endmodule

bind esc_wdog_top esc_wdog_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .unlock   (ctrl_unlock),
    .tmo_irq  (tmo_irq),
    .tmo_esc  (tmo_esc),
    .trig     (trig),
    .pend_clr (pend_clr),
    .pend     (pend),
    .count    (wd_count),
    .esc_o    (esc_o)
);

// File: tb/esc_wdog_top_tb_top.sv
`timescale 1ns/1ps
module esc_wdog_top_tb_top;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        esc_o;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    esc_wdog_top #(.TICK_DIV(DIV), .CNT_W(16)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .esc_o     (esc_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = int'(bus_rdata);
        bus_sel = 1'b0;
    endtask

    // edges until the chosen output is high (0 = irq_o, 1 = esc_o)
    task automatic wait_out(input bit pick_esc, output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!(pick_esc ? esc_o : irq_o) && n < 2000);
    endtask

    task automatic setup(input int n, input int m);
        wr(5'h00, 32'h6);
        wr(5'h04, n);
        wr(5'h08, m);
        wr(5'h10, 32'h1);
    endtask

    task automatic t_reset();
        int v;
        foreach (v_addr[i]) begin
            rd(v_addr[i], v);
            check("R1 register after reset", v, 0);
        end
        repeat (20) @(posedge clk);
        @(negedge clk);
        rd(5'h0C, v);
        check("R1 count idle", v, 0);
        check("R1 irq_o", int'(irq_o), 0);
        check("R1 esc_o", int'(esc_o), 0);
    endtask

    logic [4:0] v_addr [5] = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10};

    task automatic t_regmap();
        int v;
        wr(5'h10, 32'h1);
        rd(5'h10, v);
        check("R2 mask readback", v, 1);
        wr(5'h00, 32'h7);
        rd(5'h00, v);
        check("R2 ctrl readback trigger reads 0", v, 6);
        rd(5'h14, v);
        check("R2 unmapped offset", v, 0);
        wr(5'h00, 32'h4);
        wr(5'h04, 32'd5);
        wr(5'h08, 32'd3);
        rd(5'h04, v);
        check("R3 locked irq timeout", v, 0);
        rd(5'h08, v);
        check("R3 locked esc timeout", v, 0);
        wr(5'h00, 32'h6);
        wr(5'h04, 32'd5);
        wr(5'h08, 32'd3);
        rd(5'h04, v);
        check("R3 unlocked irq timeout", v, 5);
        rd(5'h08, v);
        check("R3 unlocked esc timeout", v, 3);
    endtask

    task automatic t_count();
        int v;
        setup(5, 3);
        wr(5'h00, 32'h7);
        rd(5'h0C, v);
        check("R4 count after trigger", v, 5);
        repeat (DIV) @(posedge clk);
        @(negedge clk);
        rd(5'h0C, v);
        check("R4 count after one tick", v, 4);
        repeat (DIV) @(posedge clk);
        @(negedge clk);
        rd(5'h0C, v);
        check("R4 count after two ticks", v, 3);
    endtask

    task automatic t_stages();
        int v, n;
        setup(3, 2);
        wr(5'h00, 32'h7);
        wait_out(1'b0, n);
        check("R5 irq edges after trigger", n, 3 * DIV);
        rd(5'h0C, v);
        check("R5 count loads second timeout", v, 2);
        wait_out(1'b1, n);
        check("R8 esc edges after irq", n, 2 * DIV);
        rd(5'h0C, v);
        check("R8 count zero at pulse", v, 0);
        @(posedge clk);
        @(negedge clk);
        check("R8 esc one cycle", int'(esc_o), 0);
        repeat (3 * DIV) @(posedge clk);
        @(negedge clk);
        rd(5'h0C, v);
        check("R8 count parked", v, 0);
        check("R8 no second esc", int'(esc_o), 0);
    endtask

    task automatic t_mask();
        setup(2, 9);
        wr(5'h10, 32'h0);
        wr(5'h00, 32'h7);
        repeat (2 * DIV + 1) @(posedge clk);
        @(negedge clk);
        check("R6 irq masked", int'(irq_o), 0);
        wr(5'h10, 32'h1);
        check("R6 pending shown after unmask", int'(irq_o), 1);
    endtask

    task automatic t_clear();
        int n;
        wr(5'h00, 32'h2);
        check("R7 drop via enable 0", int'(irq_o), 0);
        setup(2, 9);
        wr(5'h00, 32'h7);
        wait_out(1'b0, n);
        check("R7 irq before retrigger", int'(irq_o), 1);
        wr(5'h00, 32'h7);
        check("R7 drop via trigger", int'(irq_o), 0);
    endtask

    task automatic t_disable();
        int v;
        setup(0, 0);
        wr(5'h00, 32'h7);
        repeat (10 * DIV) @(posedge clk);
        @(negedge clk);
        rd(5'h0C, v);
        check("R9 disabled count", v, 0);
        check("R9 disabled irq", int'(irq_o), 0);
        check("R9 disabled esc", int'(esc_o), 0);
        setup(8, 8);
        wr(5'h00, 32'h7);
        repeat (DIV) @(posedge clk);
        @(negedge clk);
        wr(5'h04, 0);
        wr(5'h08, 0);
        repeat (20 * DIV) @(posedge clk);
        @(negedge clk);
        rd(5'h0C, v);
        check("R9 stopped while running", v, 0);
        check("R9 no irq after stop", int'(irq_o), 0);
    endtask

    task automatic t_prio();
        int v, n;
        setup(3, 4);
        wr(5'h00, 32'h7);
        repeat (3 * DIV - 1) @(posedge clk);
        @(negedge clk);
        wr(5'h00, 32'h7);
        check("R10 no irq at collision", int'(irq_o), 0);
        rd(5'h0C, v);
        check("R10 count reloaded", v, 3);
        wait_out(1'b0, n);
        check("R10 next irq full interval", n, 3 * DIV);
    endtask

    task automatic t_retrig();
        int n;
        setup(4, 4);
        wr(5'h00, 32'h7);
        repeat (4 * DIV - 3) @(posedge clk);
        @(negedge clk);
        wr(5'h00, 32'h7);
        wait_out(1'b0, n);
        check("R11 irq after retrigger", n, 4 * DIV);
    endtask

    task automatic t_zero();
        int n;
        setup(0, 2);
        wr(5'h00, 32'h7);
        wait_out(1'b0, n);
        check("R12 zero first stage one tick", n, DIV);
        wait_out(1'b1, n);
        check("R12 second stage", n, 2 * DIV);
        setup(2, 0);
        wr(5'h00, 32'h7);
        wait_out(1'b0, n);
        check("R12 first stage", n, 2 * DIV);
        wait_out(1'b1, n);
        check("R12 zero second stage one tick", n, DIV);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_count();
        t_stages();
        t_mask();
        t_clear();
        t_disable();
        t_prio();
        t_retrig();
        t_zero();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule